// File: doc/BRIEF.md
# Dual-Width Converter Host Register Interface

This block sits between a host bus and the control sequencer of a data converter. The host drives chip-select, read and write strobes that are not timed to the system clock. The block passes them through synchronisers, detects the end of each strobe, and uses those edges to load a 13-bit configuration register and to step through the 13-bit conversion result. The block presents the result on its data output. It reports three kinds of single-cycle events to the sequencer: a command was written, the host has finished reading and a new conversion should begin, and which half of the result was just read.

A width-select input picks one of two bus modes. In word mode every access moves the whole 13-bit value in one strobe. In byte mode the host moves the value in two strobes. A write to the lower half must set the upper-byte enable bit, or the next write lands on the lower half again. In byte mode a command takes effect only when the upper half is written. On the read side the lower byte comes first and the upper byte second. The upper byte is sign-extended. Only the rising edge of the second read can request a conversion.

Top module: `cvt_host_regif`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every configuration field, `dout` and every event output read zero.
- R2: In word mode (`bus_wide`=1), one write loads the whole register from `din`. The fields are: channel at bits 3:0, acquisition time at bits 5:4, upper-byte enable at bit 7, command at bits 10:8, sync-mode at bit 11 and byte-width at bit 12.
- R3: `cmd_evt` pulses for one cycle each time a write completes the command field. In word mode that is every write. In byte mode it is the upper-byte write only.
- R4: In byte mode a write loads `din[7:0]` into bits 7:0. When `din[7]` is 1, the following write loads `din[4:0]` into bits 12:8.
- R5: In byte mode a lower-half write with `din[7]`=0 leaves the write pointer on the lower half, and the command field stays unchanged.
- R6: In word mode `dout` equals `result`. The rising edge of a read pulses `conv_trig` when the command field holds START (code 3).
- R7: A read never pulses `conv_trig` unless the command field holds START. The other codes are none=0, calibrate=1, auto-zero=2, standby=4 and reset=5.
- R8: In byte mode the first read presents `result[7:0]` and the second read presents the upper byte. The upper byte is `result[12:8]` with `result[12]` repeated in bits 7:5. Each read pulses `rd_lo_evt` or `rd_hi_evt` to match the byte it read.
- R9: In byte mode `conv_trig` pulses only on the rising edge of the second read, never on the first.
- R10: A strobe that occurs while `cs_n` is high changes no register and raises no event.
- R11: Any change of `bus_wide` returns both the read pointer and the write pointer to the lower half.
- R12: In byte mode `dout[12:8]` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wide | input | 1 | 1 selects word mode, 0 selects byte mode |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| din | input | 13 | Host write data, held stable around the write strobe |
| result | input | 13 | Conversion result from the sequencer |
| dout | output | 13 | Read data presented to the host |
| chan | output | 4 | Multiplexer channel field |
| acq | output | 2 | Acquisition-time field |
| sync_mode | output | 1 | Sync-mode bit |
| bw_bit | output | 1 | Byte-width bit |
| cmd | output | 3 | Command field |
| cmd_evt | output | 1 | One-cycle pulse when a command is written |
| conv_trig | output | 1 | One-cycle pulse requesting a conversion |
| rd_lo_evt | output | 1 | One-cycle pulse after a lower-byte read |
| rd_hi_evt | output | 1 | One-cycle pulse after an upper-byte read |

## Verification
The bench writes the register in word mode, in byte mode with the enable bit set, and in byte mode with the enable bit clear. These three cases separate a correct pointer from one that always advances or never advances.

Reads use one result with the top bit set and one with it clear. This exposes a missing or misplaced sign extension and a swapped byte order. Reads are also made with and without START loaded, which shows whether triggering is gated on the command and whether it fires on the correct read of the pair.

The bench also toggles the width select in the middle of a byte pair and raises strobes while the chip is deselected. These cases catch a pointer that survives a mode change and accesses that ignore chip select.

// File: rtl/cvt_regif_pkg.sv
package cvt_regif_pkg;
  localparam int CFG_W    = 13;
  localparam int BYTE_W   = 8;
  localparam int CHAN_LSB = 0;
  localparam int CHAN_W   = 4;
  localparam int ACQ_LSB  = 4;
  localparam int ACQ_W    = 2;
  localparam int HB_BIT   = 7;
  localparam int CMD_LSB  = 8;
  localparam int CMD_W    = 3;
  localparam int SYNC_BIT = 11;
  localparam int BW_BIT   = 12;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE  = 3'd0,
    CMD_CAL   = 3'd1,
    CMD_AZERO = 3'd2,
    CMD_START = 3'd3,
    CMD_STBY  = 3'd4,
    CMD_RESET = 3'd5
  } cmd_e;

  localparam int STB_CS = 0;
  localparam int STB_RD = 1;
  localparam int STB_WR = 2;
  localparam int STB_N  = 3;
endpackage

// File: rtl/regif_strobe_sync.sv
module regif_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] pipe [STAGES];
  logic [N-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
      last <= '1;
    end else begin
      pipe[0] <= async_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      last <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/regif_cfg_wr.sv
module regif_cfg_wr
  import cvt_regif_pkg::*;
#(
  parameter int W  = CFG_W,
  parameter int BW = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wide,
  input  logic         clr_ptr,
  input  logic         wr_stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] cfg,
  output logic         cmd_pulse
);
  localparam int UP_W = W - BW;
  logic wptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= '0;
      wptr      <= 1'b0;
      cmd_pulse <= 1'b0;
    end else begin
      cmd_pulse <= 1'b0;
      if (clr_ptr) begin
        wptr <= 1'b0;
      end else if (wr_stb) begin
        if (wide) begin
          cfg       <= din;
          cmd_pulse <= 1'b1;
        end else if (!wptr) begin
          cfg[BW-1:0] <= din[BW-1:0];
          wptr        <= din[HB_BIT];
        end else begin
          cfg[W-1:BW] <= din[UP_W-1:0];
          wptr        <= 1'b0;
          cmd_pulse   <= 1'b1;
        end
      end
    end
  end

  // R4
  byte_cmd_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_pulse && $past(!wide)) |-> $past(wptr));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_stb) |-> $stable(cfg));

  // R11
  wptr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_ptr) |-> !wptr);
endmodule

// File: rtl/regif_rd_path.sv
module regif_rd_path
  import cvt_regif_pkg::*;
#(
  parameter int RW = CFG_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide,
  input  logic          clr_ptr,
  input  logic          rd_stb,
  input  logic          start_armed,
  input  logic [RW-1:0] result,
  output logic [RW-1:0] dout,
  output logic          conv_trig,
  output logic          rd_lo_evt,
  output logic          rd_hi_evt
);
  localparam int PAD = RW - BW;
  localparam int EXT = 2 * BW - RW;

  logic          rptr;
  logic [BW-1:0] lo_byte, hi_byte;

  assign lo_byte = result[BW-1:0];
  assign hi_byte = {{EXT{result[RW-1]}}, result[RW-1:BW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= '0;
      rptr      <= 1'b0;
      conv_trig <= 1'b0;
      rd_lo_evt <= 1'b0;
      rd_hi_evt <= 1'b0;
    end else begin
      conv_trig <= 1'b0;
      rd_lo_evt <= 1'b0;
      rd_hi_evt <= 1'b0;
      if (wide) dout <= result;
      else      dout <= {{PAD{1'b0}}, (rptr ? hi_byte : lo_byte)};
      if (clr_ptr) begin
        rptr <= 1'b0;
      end else if (rd_stb) begin
        if (wide) begin
          conv_trig <= start_armed;
        end else if (!rptr) begin
          rptr      <= 1'b1;
          rd_lo_evt <= 1'b1;
        end else begin
          rptr      <= 1'b0;
          rd_hi_evt <= 1'b1;
          conv_trig <= start_armed;
        end
      end
    end
  end

  // R8
  byte_evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_lo_evt, rd_hi_evt}));

  // R8
  sign_rep_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!wide && rptr && !clr_ptr) |-> (dout[BW-1:BW-EXT] == {EXT{dout[BW-EXT-1]}}));

  // R9
  byte_trig_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_trig && $past(!wide)) |-> rd_hi_evt);

  // R11
  rptr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clr_ptr) |-> !rptr);
endmodule

// File: rtl/cvt_host_regif.sv
module cvt_host_regif
  import cvt_regif_pkg::*;
#(
  parameter int DW          = CFG_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wide,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] result,
  output logic [DW-1:0] dout,
  output logic [3:0]    chan,
  output logic [1:0]    acq,
  output logic          sync_mode,
  output logic          bw_bit,
  output logic [2:0]    cmd,
  output logic          cmd_evt,
  output logic          conv_trig,
  output logic          rd_lo_evt,
  output logic          rd_hi_evt
);
  logic [STB_N-1:0] stb_lvl, stb_rise, stb_raw;
  logic             wide_q, clr_ptr, cs_act, rd_stb, wr_stb, start_armed;
  logic [DW-1:0]    cfg;

  assign stb_raw[STB_CS] = cs_n;
  assign stb_raw[STB_RD] = rd_n;
  assign stb_raw[STB_WR] = wr_n;

  regif_strobe_sync #(.N(STB_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(stb_raw), .lvl(stb_lvl), .rise(stb_rise)
  );

  assign cs_act = ~stb_lvl[STB_CS];
  assign rd_stb = stb_rise[STB_RD] & cs_act;
  assign wr_stb = stb_rise[STB_WR] & cs_act;

  always_ff @(posedge clk) begin
    if (rst) wide_q <= bus_wide;
    else     wide_q <= bus_wide;
  end
  assign clr_ptr = bus_wide ^ wide_q;

  regif_cfg_wr #(.W(DW), .BW(BYTE_W)) u_cfg (
    .clk(clk), .rst(rst), .wide(bus_wide), .clr_ptr(clr_ptr), .wr_stb(wr_stb),
    .din(din), .cfg(cfg), .cmd_pulse(cmd_evt)
  );

  assign start_armed = (cfg[CMD_LSB +: CMD_W] == CMD_START);

  regif_rd_path #(.RW(DW), .BW(BYTE_W)) u_rd (
    .clk(clk), .rst(rst), .wide(bus_wide), .clr_ptr(clr_ptr), .rd_stb(rd_stb),
    .start_armed(start_armed), .result(result), .dout(dout),
    .conv_trig(conv_trig), .rd_lo_evt(rd_lo_evt), .rd_hi_evt(rd_hi_evt)
  );

  assign chan      = cfg[CHAN_LSB +: CHAN_W];
  assign acq       = cfg[ACQ_LSB +: ACQ_W];
  assign sync_mode = cfg[SYNC_BIT];
  assign bw_bit    = cfg[BW_BIT];
  assign cmd       = cfg[CMD_LSB +: CMD_W];

  logic unused_bits;
  assign unused_bits = &{stb_lvl[STB_RD], stb_lvl[STB_WR], stb_rise[STB_CS],
                         cfg[HB_BIT], cfg[HB_BIT-1]};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (cfg == '0 && dout == '0 && !cmd_evt && !conv_trig && !rd_lo_evt && !rd_hi_evt));

  // R7
  trig_start_chk: assert property (@(posedge clk) disable iff (rst)
    conv_trig |-> $past(start_armed));
endmodule

// File: tb/cvt_host_regif_bench.sv
module cvt_host_regif_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wide = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [12:0] din = '0, result = '0;
  logic [12:0] dout;
  logic [3:0]  chan;
  logic [1:0]  acq;
  logic        sync_mode, bw_bit, cmd_evt, conv_trig, rd_lo_evt, rd_hi_evt;
  logic [2:0]  cmd;

  always #2 clk = ~clk;

  cvt_host_regif u_cvt_host_regif (
    .clk(clk), .rst(rst), .bus_wide(bus_wide), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .din(din), .result(result), .dout(dout), .chan(chan), .acq(acq),
    .sync_mode(sync_mode), .bw_bit(bw_bit), .cmd(cmd), .cmd_evt(cmd_evt),
    .conv_trig(conv_trig), .rd_lo_evt(rd_lo_evt), .rd_hi_evt(rd_hi_evt)
  );

  int n_total = 0, n_fail = 0;
  int cmd_cnt = 0, trig_cnt = 0, lo_cnt = 0, hi_cnt = 0;
  logic [12:0] exp_q[$];
  string       tag_q[$];
  bit          sample_req = 0;

  task automatic check(string tag, int got, int exp);
    n_total++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cmd_cnt  += int'(cmd_evt);
      trig_cnt += int'(conv_trig);
      lo_cnt   += int'(rd_lo_evt);
      hi_cnt   += int'(rd_hi_evt);
    end
    if (sample_req) begin
      sample_req = 0;
      if (exp_q.size() > 0) check(tag_q.pop_front(), int'(dout), int'(exp_q.pop_front()));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(logic [12:0] v, bit sel = 1);
    @(negedge clk);
    din = v; cs_n = ~sel;
    idle(3);
    wr_n = 0;
    idle(4);
    wr_n = 1;
    idle(6);
    cs_n = 1;
    idle(2);
  endtask

  task automatic host_read(logic [12:0] expv, string tag, bit sel = 1);
    @(negedge clk);
    cs_n = ~sel;
    idle(3);
    rd_n = 0;
    idle(4);
    if (sel) begin
      exp_q.push_back(expv);
      tag_q.push_back(tag);
      @(posedge clk);
      sample_req = 1;
      @(negedge clk);
    end
    rd_n = 1;
    idle(6);
    cs_n = 1;
    idle(2);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_total++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int c0;
    idle(4);
    // R1 reset state
    check("R1 dout", int'(dout), 0);
    check("R1 cfg", int'({chan, acq, sync_mode, bw_bit, cmd}), 0);
    check("R1 events", int'({cmd_evt, conv_trig, rd_lo_evt, rd_hi_evt}), 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 after release", int'({chan, cmd, dout}), 0);

    // R2 R3 word-mode write: START, sync=1, acq=2, chan=5
    host_write(13'h0B25);
    check("R2 chan", chan, 5);
    check("R2 acq", acq, 2);
    check("R2 sync", sync_mode, 1);
    check("R2 bw", bw_bit, 0);
    check("R2 cmd", cmd, 3);
    check("R3 cmd_evt word", cmd_cnt, 1);

    // R6 word-mode read with START
    result = 13'h1A35;
    host_read(13'h1A35, "R6 dout word");
    check("R6 trig", trig_cnt, 1);

    // R7 no trigger with calibrate
    host_write(13'h0103);
    check("R7 cmd", cmd, 1);
    host_read(13'h1A35, "R7 dout word");
    check("R7 no trig", trig_cnt, 1);

    // R10 deselected access ignored
    c0 = cmd_cnt;
    host_write(13'h0B25, 0);
    check("R10 cmd unchanged", cmd, 1);
    check("R10 chan unchanged", chan, 3);
    check("R10 no cmd_evt", cmd_cnt, c0);
    host_read(13'h0, "R10", 0);
    check("R10 no trig", trig_cnt, 1);

    // R4 byte-mode two-cycle write
    bus_wide = 0; idle(4);
    c0 = cmd_cnt;
    host_write(13'h0099);
    check("R4 chan lower", chan, 9);
    check("R4 acq lower", acq, 1);
    check("R4 cmd not yet", cmd, 1);
    check("R3 no evt on lower", cmd_cnt, c0);
    host_write(13'h0013);
    check("R4 cmd upper", cmd, 3);
    check("R4 bw upper", bw_bit, 1);
    check("R4 sync upper", sync_mode, 0);
    check("R3 evt on upper", cmd_cnt, c0 + 1);

    // R5 lower write without enable
    host_write(13'h0002);
    host_write(13'h0007);
    check("R5 stays lower", chan, 7);
    check("R5 cmd kept", cmd, 3);
    check("R5 no cmd_evt", cmd_cnt, c0 + 1);

    // R8 R9 R12 byte reads, negative result
    result = 13'h1A35;
    host_read(13'h0035, "R8 R12 low neg");
    check("R9 no trig on first", trig_cnt, 1);
    check("R8 lo evt", lo_cnt, 1);
    host_read(13'h00FA, "R8 R12 high neg sign");
    check("R9 trig on second", trig_cnt, 2);
    check("R8 hi evt", hi_cnt, 1);
    // positive result
    result = 13'h0ABC;
    host_read(13'h00BC, "R8 low pos");
    host_read(13'h000A, "R8 high pos");
    check("R9 trig pos", trig_cnt, 3);

    // R11 width change clears read pointer
    host_read(13'h00BC, "R11 low before toggle");
    bus_wide = 1; idle(4);
    bus_wide = 0; idle(4);
    host_read(13'h00BC, "R11 low after toggle");
    check("R11 no trig", trig_cnt, 3);

    // R11 width change clears write pointer
    c0 = cmd_cnt;
    host_write(13'h0084);
    bus_wide = 1; idle(4);
    bus_wide = 0; idle(4);
    host_write(13'h0001);
    check("R11 write lower again", chan, 1);
    check("R11 cmd kept", cmd, 3);
    check("R11 no cmd_evt", cmd_cnt, c0);

    idle(4);
    finish_up();
  end
endmodule